// File: doc/BRIEF.md
# Lane-Protected ECC Word Store

This block is a small on-chip store that guards each data lane with a hidden single-error-correcting Hamming code. The external bus is split into four 9-bit lanes, and every access moves two beats on that bus. On a write, the two beats of a lane are joined into an 18-bit word. Five check bits are computed over that word, and the 23-bit codeword is kept in a register-file array. On a read, the codeword's syndrome is recomputed and any single flipped bit is repaired. The word is then returned as two beats again. Check bits never appear on either bus.

A test input lets a chosen 23-bit pattern be XORed into each lane's codeword as it is written. This allows single-bit and multi-bit faults to be placed at any position. Each read reports, per lane, whether a correction was made and whether the syndrome pointed outside the codeword. The code has no overall parity bit. A double fault is therefore not recognised as such and may be miscorrected; that behaviour is deliberate and is specified below.

Top module: `lecc_lane_store`

## Requirements
- R1: After reset, `rd_valid`, `rd_beat`, `corr_flag` and `unc_flag` are all 0, and the flags stay 0 in every cycle where `rd_valid` is 0.
- R2: A read issued with `rd_en` in cycle c returns beat 0 of every lane on `rd_data` in cycle c+2, with `rd_valid`=1 and `rd_beat`=0. It returns beat 1 in cycle c+3, with `rd_valid`=1 and `rd_beat`=1. The flags are held constant across both beats.
- R3: Lane l uses bus bits [9l+8:9l]. The lane word is {beat 1, beat 0}, with beat 0 as bits [8:0]. In the 23-bit codeword, position p (1..23) is bit p-1. Check bits sit at positions 1, 2, 4, 8 and 16. Data bits fill the remaining positions in ascending order. Check bit k makes the XOR of all positions whose index has bit k set equal to zero.
- R4: A write with `wr_en` in cycle c takes beat 0 from `wr_data` in cycle c and beat 1 in cycle c+1. `wr_inject` is sampled in cycle c+1, and lane l's mask is bits [23l+22:23l]. A zero mask stores a clean codeword, which reads back as the written data with no flags set.
- R5: A single flipped bit at any codeword position in any lane is corrected on read. The written data is returned, and that lane's `corr_flag` bit is 1.
- R6: Lanes are decoded independently. A fault in one lane leaves every other lane's data and flags unaffected.
- R7: A syndrome of 24 to 31 leaves the stored data bits unaltered on read. It sets that lane's `unc_flag` and clears its `corr_flag`.
- R8: Two flipped bits whose positions XOR to a value in 1..23 are treated as a single error at that position. The bit there is flipped and `corr_flag` is set; no double error is reported.
- R9: While a write waits for its second beat, `wr_en` is ignored, and no other address is written.
- R10: A `rd_en` in the cycle right after an accepted read is ignored. A read accepted in the cycle after that streams its two beats directly after the first read's two beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Starts a two-beat write |
| wr_addr | input | ADDR_W | Write address, sampled with beat 0 |
| wr_data | input | 36 | Write beat data (beat 0, then beat 1) |
| wr_inject | input | 92 | Per-lane codeword fault mask, sampled with beat 1 |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address, sampled with `rd_en` |
| rd_data | output | 36 | Read beat data |
| rd_valid | output | 1 | `rd_data` carries a read beat |
| rd_beat | output | 1 | 0 for beat 0, 1 for beat 1 |
| corr_flag | output | 4 | Per-lane single-error correction made |
| unc_flag | output | 4 | Per-lane syndrome beyond codeword length |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. It counts rising edges from the cycle in which `rd_en` is driven: beat 0 is sampled two falling edges later and beat 1 one falling edge after that. Writes are complete at the second rising edge after `wr_en`, so any read issued after a write task returns sees the new codeword. Expected beats and flags come from a bench model of the stored codewords, with its own encoder and syndrome decoder. The streaming and ignored-request cases also check the cycle after the last expected beat, where `rd_valid` must be 0.

// File: rtl/lecc_pkg.sv
package lecc_pkg;
  localparam int BEAT_W = 9;
  localparam int WORD_W = 2 * BEAT_W;
  localparam int CHK_W  = 5;
  localparam int CW_W   = WORD_W + CHK_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [CHK_W-1:0]  syn_t;

  // Scatter data bits into the non-power-of-two positions, ascending.
  function automatic cw_t spread_data(word_t d);
    cw_t r;
    int  k;
    r = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r[p-1] = d[k];
        k++;
      end
    end
    return r;
  endfunction

  function automatic word_t gather_data(cw_t c);
    word_t r;
    int    k;
    r = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r[k] = c[p-1];
        k++;
      end
    end
    return r;
  endfunction

  // XOR of the indices of all set positions.
  function automatic syn_t calc_syndrome(cw_t c);
    syn_t s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (c[p-1]) s = s ^ syn_t'(p);
    end
    return s;
  endfunction

  function automatic cw_t build_codeword(word_t d);
    cw_t  c;
    syn_t s;
    c = spread_data(d);
    s = calc_syndrome(c);
    for (int i = 0; i < CHK_W; i++) c[(1 << i) - 1] = s[i];
    return c;
  endfunction
endpackage

// File: rtl/lecc_encoder.sv
module lecc_encoder
  import lecc_pkg::*;
(
  input  word_t data_i,
  input  cw_t   inj_i,
  output cw_t   cw_o
);
  cw_t clean;

  always_comb begin
    clean = build_codeword(data_i);
    cw_o  = clean ^ inj_i;
  end
endmodule

// File: rtl/lecc_decoder.sv
module lecc_decoder
  import lecc_pkg::*;
(
  input  cw_t   cw_i,
  output word_t data_o,
  output logic  corr_o,
  output logic  unc_o
);
  syn_t syn;
  cw_t  fixed;

  always_comb begin
    syn    = calc_syndrome(cw_i);
    fixed  = cw_i;
    corr_o = 1'b0;
    unc_o  = 1'b0;
    if (syn != '0) begin
      if (int'(syn) <= CW_W) begin
        fixed[int'(syn) - 1] = ~cw_i[int'(syn) - 1];
        corr_o = 1'b1;
      end else begin
        unc_o = 1'b1;
      end
    end
    data_o = gather_data(fixed);
  end
endmodule

// File: rtl/lecc_array.sv
module lecc_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 92,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  // R9: a two-beat write never produces back-to-back array writes
  a_r9_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
endmodule

// File: rtl/lecc_lane_store.sv
module lecc_lane_store
  import lecc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 4,
  localparam int BUS_W = LANES * BEAT_W,
  localparam int INJ_W = LANES * CW_W,
  localparam int DAT_W = LANES * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [INJ_W-1:0]  wr_inject,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              rd_beat,
  output logic [LANES-1:0]  corr_flag,
  output logic [LANES-1:0]  unc_flag
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // write side: hold beat 0, encode and store on beat 1
  logic              wr_ph_q, wr_ph_d, wr_ld;
  logic [ADDR_W-1:0] wa_q;
  logic [BUS_W-1:0]  b0_q;
  logic [INJ_W-1:0]  enc_cw;

  assign wr_ld = wr_en && !wr_ph_q;

  always_comb begin
    wr_ph_d = wr_ph_q;
    if (wr_ph_q)    wr_ph_d = 1'b0;
    else if (wr_en) wr_ph_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) wr_ph_q <= 1'b0;
    else        wr_ph_q <= wr_ph_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ld) begin
      wa_q <= wr_addr;
      b0_q <= wr_data;
    end
  end

  // read side
  logic              rd_ld, rd_s1_q, rd_s1_d;
  logic              vld_q, vld_d, beat_q, beat_d;
  logic [LANES-1:0]  corr_q, corr_d, unc_q, unc_d;
  logic [INJ_W-1:0]  arr_rdata;
  logic [DAT_W-1:0]  dec_data, dat_q;
  logic [LANES-1:0]  dec_corr, dec_unc;

  assign rd_ld = rd_en && !rd_s1_q;

  lecc_array #(.ADDR_W(ADDR_W), .DATA_W(INJ_W)) u_array (
    .clk   (clk),
    .rst_n (rst_s),
    .we    (wr_ph_q),
    .waddr (wa_q),
    .wdata (enc_cw),
    .re    (rd_ld),
    .raddr (rd_addr),
    .rdata (arr_rdata)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    word_t wword;
    assign wword = {wr_data[l*BEAT_W +: BEAT_W], b0_q[l*BEAT_W +: BEAT_W]};

    lecc_encoder u_enc (
      .data_i (wword),
      .inj_i  (wr_inject[l*CW_W +: CW_W]),
      .cw_o   (enc_cw[l*CW_W +: CW_W])
    );

    lecc_decoder u_dec (
      .cw_i   (arr_rdata[l*CW_W +: CW_W]),
      .data_o (dec_data[l*WORD_W +: WORD_W]),
      .corr_o (dec_corr[l]),
      .unc_o  (dec_unc[l])
    );

    assign rd_data[l*BEAT_W +: BEAT_W] = beat_q ? dat_q[l*WORD_W + BEAT_W +: BEAT_W]
                                                : dat_q[l*WORD_W +: BEAT_W];
  end

  always_comb begin
    rd_s1_d = rd_ld;
    vld_d   = 1'b0;
    beat_d  = 1'b0;
    corr_d  = '0;
    unc_d   = '0;
    if (rd_s1_q) begin
      vld_d  = 1'b1;
      corr_d = dec_corr;
      unc_d  = dec_unc;
    end else if (vld_q && !beat_q) begin
      vld_d  = 1'b1;
      beat_d = 1'b1;
      corr_d = corr_q;
      unc_d  = unc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rd_s1_q <= 1'b0;
      vld_q   <= 1'b0;
      beat_q  <= 1'b0;
      corr_q  <= '0;
      unc_q   <= '0;
    end else begin
      rd_s1_q <= rd_s1_d;
      vld_q   <= vld_d;
      beat_q  <= beat_d;
      corr_q  <= corr_d;
      unc_q   <= unc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_s1_q) dat_q <= dec_data;
  end

  assign rd_valid  = vld_q;
  assign rd_beat   = beat_q;
  assign corr_flag = corr_q;
  assign unc_flag  = unc_q;

  // R1: flags only while a beat is presented
  a_r1_idle_flags: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_valid |-> (corr_flag == '0 && unc_flag == '0));

  // R2: beat 0 is always followed by beat 1
  a_r2_beat_order: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_valid && !rd_beat) |=> (rd_valid && rd_beat));

  // R2: flags unchanged between the two beats
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_valid && rd_beat) |-> ($stable(corr_flag) && $stable(unc_flag)));

  // R7: a lane is never both corrected and out of range
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_s)
    (corr_flag & unc_flag) == '0);

  // R10: a fresh output burst starts with beat 0
  a_r10_burst_start: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rd_valid) |-> !rd_beat);
endmodule

// File: tb/test_lecc_lane_store.sv
module test_lecc_lane_store;
  localparam int LN = 4;
  localparam int AW = 4;
  localparam int CW = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [35:0]   wr_data = '0;
  logic [91:0]   wr_inject = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [35:0]   rd_data;
  logic          rd_valid, rd_beat;
  logic [LN-1:0] corr_flag, unc_flag;

  int nchk = 0;
  int nfail = 0;
  logic [91:0] ref_cw [16];

  always #10 clk = ~clk;

  lecc_lane_store i_lecc_lane_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_inject(wr_inject), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_beat(rd_beat), .corr_flag(corr_flag), .unc_flag(unc_flag)
  );

  function automatic logic [22:0] ref_encode(logic [17:0] d);
    logic [22:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= 23; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
        c[p-1] = d[j];
        j++;
      end
    end
    for (int b = 0; b < 5; b++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p <= 23; p++) if (((p >> b) & 1) == 1) par = par ^ c[p-1];
      c[(1 << b) - 1] = par;
    end
    return c;
  endfunction

  task automatic ref_decode(input logic [22:0] c, output logic [17:0] d,
                            output logic cf, output logic uf);
    int s;
    int j;
    s = 0;
    for (int p = 1; p <= 23; p++) if (c[p-1]) s = s ^ p;
    cf = 1'b0;
    uf = 1'b0;
    if (s >= 1 && s <= 23) begin
      c[s-1] = ~c[s-1];
      cf = 1'b1;
    end else if (s > 23) begin
      uf = 1'b1;
    end
    j = 0;
    for (int p = 1; p <= 23; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
        d[j] = c[p-1];
        j++;
      end
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_read(input int a, output logic [35:0] e0, output logic [35:0] e1,
                             output logic [3:0] ec, output logic [3:0] eu);
    for (int l = 0; l < LN; l++) begin
      logic [17:0] d;
      logic cf, uf;
      ref_decode(ref_cw[a][l*CW +: CW], d, cf, uf);
      e0[l*9 +: 9] = d[8:0];
      e1[l*9 +: 9] = d[17:9];
      ec[l] = cf;
      eu[l] = uf;
    end
  endtask

  task automatic do_write(input int a, input logic [35:0] d0, input logic [35:0] d1,
                          input logic [91:0] inj, input bit hold, input int other);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d0;
    @(negedge clk);
    wr_en = hold; wr_addr = AW'(hold ? other : a); wr_data = d1; wr_inject = inj;
    @(negedge clk);
    wr_en = 1'b0; wr_inject = '0;
    for (int l = 0; l < LN; l++)
      ref_cw[a][l*CW +: CW] = ref_encode({d1[l*9 +: 9], d0[l*9 +: 9]}) ^ inj[l*CW +: CW];
  endtask

  task automatic do_read(input int a, input string dtag, input string ftag);
    logic [35:0] e0, e1, s0, s1;
    logic [3:0]  ec, eu, c0, u0;
    logic [1:0]  st0, st1;
    expect_read(a, e0, e1, ec, eu);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    s0 = rd_data; st0 = {rd_valid, rd_beat}; c0 = corr_flag; u0 = unc_flag;
    @(negedge clk);
    s1 = rd_data; st1 = {rd_valid, rd_beat};
    check("R2 beat timing", {60'd0, st0, st1}, {60'd0, 2'b10, 2'b11});
    check({dtag, " beat0"}, s0, e0);
    check({dtag, " beat1"}, s1, e1);
    check({ftag, " corr_flag"}, c0, ec);
    check({ftag, " unc_flag"}, u0, eu);
  endtask

  function automatic logic [35:0] rnd36();
    return {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 reset outputs", {54'd0, rd_valid, rd_beat, corr_flag, unc_flag}, 64'd0);

    // R4, R2: clean writes over all addresses, then read back
    for (int a = 0; a < 16; a++) do_write(a, rnd36(), rnd36(), '0, 1'b0, 0);
    do_write(5, 36'h0_0000_0000, 36'hF_FFFF_FFFF, '0, 1'b0, 0);
    do_read(5, "R4 clean data", "R4 clean flags");
    do_write(6, 36'hA_5A5A_5A5A, 36'h5_A5A5_A5A5, '0, 1'b0, 0);
    do_read(6, "R4 clean data", "R4 clean flags");
    for (int a = 0; a < 4; a++) do_read(a, "R2 clean data", "R2 clean flags");

    // R5, R6, R3: every single-bit position in every lane
    for (int l = 0; l < LN; l++) begin
      for (int p = 1; p <= 23; p++) begin
        logic [91:0] m;
        m = '0;
        m[l*CW + p - 1] = 1'b1;
        do_write(p % 16, rnd36(), rnd36(), m, 1'b0, 0);
        if ((p & (p - 1)) == 0) do_read(p % 16, "R3 check-bit fault data", "R6 lane flags");
        else do_read(p % 16, "R5 single fault data", "R6 lane flags");
      end
    end

    // R7: syndrome out of range (23^15 = 24, 31^... via 16^8 = 24)
    begin
      logic [91:0] m;
      m = '0;
      m[22] = 1'b1; m[14] = 1'b1;               // lane 0: positions 23,15
      m[CW + 15] = 1'b1; m[CW + 7] = 1'b1;      // lane 1: positions 16,8
      do_write(7, rnd36(), rnd36(), m, 1'b0, 0);
      do_read(7, "R7 out-of-range data", "R7 out-of-range flags");
      m = '0;
      m[3*CW + 22] = 1'b1; m[3*CW + 8] = 1'b1;  // lane 3: positions 23,9 -> 30
      do_write(8, rnd36(), rnd36(), m, 1'b0, 0);
      do_read(8, "R7 out-of-range data", "R7 out-of-range flags");
    end

    // R8: double faults that alias a single position
    begin
      logic [91:0] m;
      m = '0;
      m[0] = 1'b1; m[1] = 1'b1;                 // lane 0: 1^2 = 3, flips data bit 0
      m[2*CW + 4] = 1'b1; m[2*CW + 5] = 1'b1;   // lane 2: 5^6 = 3
      do_write(9, 36'h0_0000_0000, 36'h0_0000_0000, m, 1'b0, 0);
      do_read(9, "R8 aliased double data", "R8 aliased double flags");
    end

    // R9: wr_en during second beat ignored
    begin
      logic [91:0] keep;
      do_write(11, rnd36(), rnd36(), '0, 1'b0, 0);
      keep = ref_cw[11];
      do_write(10, rnd36(), rnd36(), '0, 1'b1, 11);
      repeat (2) @(negedge clk);
      check("R9 shadow address untouched", {36'd0, 28'(keep == ref_cw[11])}, 64'd1);
      do_read(11, "R9 ignored write data", "R9 ignored write flags");
      do_read(10, "R9 real write data", "R9 real write flags");
    end

    // R10: ignored request then streamed read
    begin
      logic [35:0] a0, a1, b0, b1, x;
      logic [3:0]  ec, eu;
      logic [1:0]  st [4];
      logic [35:0] got [4];
      expect_read(1, a0, a1, ec, eu);
      expect_read(2, b0, b1, ec, eu);
      @(negedge clk); rd_en = 1'b1; rd_addr = 4'd1;
      @(negedge clk); rd_addr = 4'd3;
      @(negedge clk); rd_addr = 4'd2;
      got[0] = rd_data; st[0] = {rd_valid, rd_beat};
      @(negedge clk); rd_en = 1'b0;
      got[1] = rd_data; st[1] = {rd_valid, rd_beat};
      @(negedge clk);
      got[2] = rd_data; st[2] = {rd_valid, rd_beat};
      @(negedge clk);
      got[3] = rd_data; st[3] = {rd_valid, rd_beat};
      @(negedge clk);
      x = {35'd0, rd_valid};
      check("R10 stream beat A0", got[0], a0);
      check("R10 stream beat A1", got[1], a1);
      check("R10 stream beat B0", got[2], b0);
      check("R10 stream beat B1", got[3], b1);
      check("R10 stream status", {56'd0, st[0], st[1], st[2], st[3]}, {56'd0, 8'b10111011});
      check("R10 idle after stream", x, 36'd0);
    end

    // random mix, R5/R6 under random traffic
    for (int i = 0; i < 150; i++) begin
      int a;
      a = int'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) begin
        logic [91:0] m;
        m = '0;
        if ($urandom_range(0, 2) == 0) m[$urandom_range(0, 91)] = 1'b1;
        do_write(a, rnd36(), rnd36(), m, 1'b0, 0);
      end else begin
        do_read(a, "R5 random data", "R6 random flags");
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule